// File: doc/BRIEF.md
# Leaf Entry Permission Check and Reference/Change Update

This block sits beside a radix page-table walker. Once the walker has found a leaf entry, the walker presents it here with several pieces of context: the kind of access (load, store or instruction fetch), whether the processor runs in problem (user) state, whether the entry came from the partition-scoped tree, and the read/write/execute rights that the authority mask currently allows.

One cycle later the block reports three things. The first is the rights the page grants. The second is whether the access must fault, and with which cause bits. The third is the entry as it should look after use: the reference bit is set, and the change bit is set for a store.

A write-back request is raised only when that new entry differs from the old one. The memory write itself is done elsewhere. For loads and fetches, write permission is removed from the reported rights. A later store to the same page therefore comes back through this block and sets the change bit.

Top module: `pte_prot_rc`

## Requirements
- R1: While reset is held, `resp_valid`, `resp_fault` and `resp_writeback` are 0.
- R2: Every response appears exactly one clock after the cycle in which `req_valid` is high. `resp_valid` and `resp_writeback` are 0 in the cycle after a cycle without a request.
- R3: Entry bits [5:4] hold the memory attribute, and the value 2'b10 means non-idempotent I/O. If an instruction fetch (access code 2'b10) meets such an entry, the result is a fault with cause bit 28 (no-execute) alone, rights 3'b000, and no write-back.
- R4: Entry bit 3 marks a privileged page. A process-scoped (`req_partition`=0), privileged page accessed in problem state is granted no rights.
- R5: Entry bits [2:0] are the encoded authority: bit 2 allows read, bit 1 allows read and write, bit 0 allows execute. In problem state, on privileged pages, or for partition-scoped entries, the rights come from these bits only. Rights are reported as {read, write, execute} in bits [2:0].
- R6: For a supervisor access to a non-privileged, process-scoped page, the encoded rights are ANDed bitwise with `req_amr_rights`.
- R7: Each access needs one right: a load (2'b00, and also the unused code 2'b11) needs read, a store (2'b01) needs write, and a fetch needs execute. If that right is missing, the access faults. A fetch sets cause bit 28. A load or store sets cause bit 27, and a store also sets bit 25. All other cause bits are 0, and a fault returns the entry unchanged.
- R8: On a permitted access, the returned entry has reference bit 8 set. Change bit 7 is also set if the access is a store. All other bits are copied.
- R9: On a permitted load or fetch, the write right is cleared in `resp_rights`. On a permitted store, the computed rights are returned unchanged.
- R10: `resp_writeback` is 1 exactly when a permitted access produces an entry different from the one presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per entry |
| req_pte | input | PTE_W | Leaf entry to check |
| req_access | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as load |
| req_problem | input | 1 | Access made in problem (user) state |
| req_partition | input | 1 | Entry belongs to the partition-scoped tree |
| req_amr_rights | input | 3 | {r,w,x} allowed by the authority mask |
| resp_valid | output | 1 | Response strobe |
| resp_fault | output | 1 | Access must fault |
| resp_cause | output | CAUSE_W | Fault cause bits (28, 27, 25) |
| resp_rights | output | 3 | Granted {r,w,x} |
| resp_pte | output | PTE_W | Entry after reference/change update |
| resp_writeback | output | 1 | Entry changed and must be written back |

## Verification
The main check sweeps every combination of access code, problem state, scope, mask value, the four authority and privilege bits, the attribute field, and the prior reference and change bits. This covers all four permission paths (blocked, direct, masked, attribute fault). Because the prior reference and change bits are swept, the sweep also shows whether the write-back follows a real change in the entry and is not sent on every permitted access. The mask sweep shows that the mask applies only to the supervisor, non-privileged, process-scoped case. Comparing loads with stores on the same entry shows whether write rights are withheld and whether the change bit is set.

// File: rtl/pte_prot_pkg.sv
package pte_prot_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rights_t;

  localparam int ATT_LO       = 4;
  localparam int ATT_HI       = 5;
  localparam logic [1:0] ATT_NI_IO = 2'b10;
  localparam int AUTH_LO      = 0;
  localparam int AUTH_HI      = 3;
  localparam int AUTH_PRIV    = 3;
  localparam int REF_BIT      = 8;
  localparam int CHG_BIT      = 7;

  localparam int CAUSE_NOEXEC = 28;
  localparam int CAUSE_PROT   = 27;
  localparam int CAUSE_STORE  = 25;

  // Expand the three encoded authority bits into explicit rights.
  function automatic rights_t auth_to_rights(input logic [2:0] enc);
    rights_t t;
    t.r = enc[2] | enc[1];
    t.w = enc[1];
    t.x = enc[0];
    return t;
  endfunction

  // The single right an access kind depends on.
  function automatic rights_t needed_right(input acc_e acc);
    rights_t t;
    t = '0;
    case (acc)
      ACC_STORE: t.w = 1'b1;
      ACC_FETCH: t.x = 1'b1;
      default:   t.r = 1'b1;
    endcase
    return t;
  endfunction

  function automatic logic is_store(input acc_e acc);
    return acc == ACC_STORE;
  endfunction

endpackage

// File: rtl/pte_auth_decode.sv
module pte_auth_decode
  import pte_prot_pkg::*;
(
  input  logic [AUTH_HI-AUTH_LO:0] auth,
  input  logic                     problem,
  input  logic                     partition,
  input  logic [2:0]               amr,
  output rights_t                  rights,
  output logic                     priv_block,
  output logic                     amr_applied
);

  rights_t enc_rights;
  logic    priv;

  always_comb begin
    priv        = auth[AUTH_PRIV-AUTH_LO];
    enc_rights  = auth_to_rights(auth[2:0]);
    priv_block  = !partition && priv && problem;
    amr_applied = !partition && !priv && !problem;
    if (priv_block)
      rights = '0;
    else if (amr_applied)
      rights = enc_rights & rights_t'(amr);
    else
      rights = enc_rights;
  end

endmodule

// File: rtl/pte_fault_check.sv
module pte_fault_check
  import pte_prot_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input  logic [1:0]         att,
  input  acc_e               access,
  input  rights_t            perm,
  output logic               att_fault,
  output logic               prot_fault,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);

  rights_t need;

  always_comb begin
    need       = needed_right(access);
    att_fault  = (att == ATT_NI_IO) && (access == ACC_FETCH);
    prot_fault = |(need & ~perm);
    fault      = att_fault | prot_fault;
    cause      = '0;
    if (att_fault) begin
      cause[CAUSE_NOEXEC] = 1'b1;
    end else if (prot_fault) begin
      if (access == ACC_FETCH) begin
        cause[CAUSE_NOEXEC] = 1'b1;
      end else begin
        cause[CAUSE_PROT]  = 1'b1;
        cause[CAUSE_STORE] = is_store(access);
      end
    end
  end

endmodule

// File: rtl/pte_rc_update.sv
module pte_rc_update
  import pte_prot_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_in,
  input  acc_e             access,
  input  logic             att_fault,
  input  logic             fault,
  input  rights_t          perm,
  output logic [PTE_W-1:0] pte_out,
  output rights_t          rights_out,
  output logic             changed
);

  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask          = '0;
    set_mask[REF_BIT] = 1'b1;
    set_mask[CHG_BIT] = is_store(access);
    pte_out    = fault ? pte_in : (pte_in | set_mask);
    changed    = !fault && (pte_out != pte_in);
    rights_out = perm;
    if (att_fault)
      rights_out = '0;
    else if (!fault && !is_store(access))
      rights_out.w = 1'b0;
  end

endmodule

// File: rtl/pte_prot_rc.sv
module pte_prot_rc
  import pte_prot_pkg::*;
#(
  parameter int PTE_W   = 64,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [PTE_W-1:0]   req_pte,
  input  logic [1:0]         req_access,
  input  logic               req_problem,
  input  logic               req_partition,
  input  logic [2:0]         req_amr_rights,
  output logic               resp_valid,
  output logic               resp_fault,
  output logic [CAUSE_W-1:0] resp_cause,
  output logic [2:0]         resp_rights,
  output logic [PTE_W-1:0]   resp_pte,
  output logic               resp_writeback
);

  acc_e               acc;
  rights_t            perm_w;
  rights_t            rights_w;
  logic               priv_block_w;
  logic               amr_applied_w;
  logic               att_fault_w;
  logic               prot_fault_w;
  logic               fault_w;
  logic [CAUSE_W-1:0] cause_w;
  logic [PTE_W-1:0]   pte_next_w;
  logic               changed_w;
  acc_e               acc_q;

  assign acc = acc_e'(req_access);

  pte_auth_decode u_auth (
    .auth        (req_pte[AUTH_HI:AUTH_LO]),
    .problem     (req_problem),
    .partition   (req_partition),
    .amr         (req_amr_rights),
    .rights      (perm_w),
    .priv_block  (priv_block_w),
    .amr_applied (amr_applied_w)
  );

  pte_fault_check #(.CAUSE_W(CAUSE_W)) u_fault (
    .att        (req_pte[ATT_HI:ATT_LO]),
    .access     (acc),
    .perm       (perm_w),
    .att_fault  (att_fault_w),
    .prot_fault (prot_fault_w),
    .fault      (fault_w),
    .cause      (cause_w)
  );

  pte_rc_update #(.PTE_W(PTE_W)) u_rc (
    .pte_in     (req_pte),
    .access     (acc),
    .att_fault  (att_fault_w),
    .fault      (fault_w),
    .perm       (perm_w),
    .pte_out    (pte_next_w),
    .rights_out (rights_w),
    .changed    (changed_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_fault     <= 1'b0;
      resp_cause     <= '0;
      resp_rights    <= '0;
      resp_pte       <= '0;
      resp_writeback <= 1'b0;
      acc_q          <= ACC_LOAD;
    end else begin
      resp_valid     <= req_valid;
      resp_writeback <= req_valid && changed_w;
      if (req_valid) begin
        resp_fault  <= fault_w;
        resp_cause  <= cause_w;
        resp_rights <= rights_w;
        resp_pte    <= pte_next_w;
        acc_q       <= acc;
      end
    end
  end

  // R2: a request yields a response on the next clock
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R10: write-back only on a permitted, valid response
  p_wb_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_writeback |-> (resp_valid && !resp_fault));

  // R8: permitted accesses leave the reference bit set
  p_ref_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> resp_pte[REF_BIT]);

  // R9: no write right handed out to a permitted non-store
  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault && acc_q != ACC_STORE) |-> !resp_rights[1]);

  // R7: a fault always carries at least one cause bit
  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_cause != '0));

  // R4: a blocked privileged page cannot let any access through
  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_block_w) |=> resp_fault);

  // R6: masked rights never exceed the mask
  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (amr_applied_w && !att_fault_w) |-> ((perm_w & ~rights_t'(req_amr_rights)) == '0));

  // R3: attribute fault reports no rights on the next cycle
  p_att_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && att_fault_w) |=> (resp_fault && resp_rights == 3'b000));

  // R7: protection and attribute faults both feed the registered flag
  p_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_fault_w) |=> resp_fault);

endmodule

// File: tb/pte_prot_rc_test.sv
`timescale 1ns/1ps
module pte_prot_rc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_pte = '0;
  logic [1:0]  req_access = '0;
  logic        req_problem = 1'b0;
  logic        req_partition = 1'b0;
  logic [2:0]  req_amr_rights = '0;
  logic        resp_valid;
  logic        resp_fault;
  logic [31:0] resp_cause;
  logic [2:0]  resp_rights;
  logic [63:0] resp_pte;
  logic        resp_writeback;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pte_prot_rc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
    .req_access(req_access), .req_problem(req_problem),
    .req_partition(req_partition), .req_amr_rights(req_amr_rights),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
    .resp_rights(resp_rights), .resp_pte(resp_pte),
    .resp_writeback(resp_writeback)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // expected-value model, written from the requirements
  logic        e_fault, e_wb;
  logic [31:0] e_cause;
  logic [2:0]  e_rights;
  logic [63:0] e_pte;
  string       e_tag;

  task automatic model(input logic [63:0] p, input logic [1:0] a,
                       input logic pr, input logic pt, input logic [2:0] m);
    logic [2:0] enc, rt, need;
    logic ni_fetch;
    enc = {p[2] | p[1], p[1], p[0]};
    ni_fetch = (p[5:4] == 2'b10) && (a == 2'b10);
    if (!pt && p[3] && pr) begin rt = 3'b000; e_tag = "R4"; end
    else if (pr || p[3] || pt) begin rt = enc; e_tag = "R5"; end
    else begin rt = enc & m; e_tag = "R6"; end
    need = (a == 2'b01) ? 3'b010 : (a == 2'b10) ? 3'b001 : 3'b100;
    e_cause = 32'h0;
    e_pte = p;
    e_wb = 1'b0;
    if (ni_fetch) begin
      e_fault = 1'b1; e_cause = 32'h1000_0000; e_rights = 3'b000; e_tag = "R3";
    end else if ((need & ~rt) != 3'b000) begin
      e_fault = 1'b1; e_rights = rt;
      e_cause = (a == 2'b10) ? 32'h1000_0000 :
                (a == 2'b01) ? 32'h0A00_0000 : 32'h0800_0000;
      e_tag = {e_tag, "/R7"};
    end else begin
      e_fault = 1'b0;
      e_pte = p | 64'h100 | ((a == 2'b01) ? 64'h80 : 64'h0);
      e_rights = (a == 2'b01) ? rt : (rt & 3'b101);
      e_wb = (e_pte != p);
      e_tag = {e_tag, (a == 2'b01) ? "/R8" : "/R8/R9"};
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!resp_valid && !resp_fault && !resp_writeback, "R1",
          $sformatf("reset outputs v=%0b f=%0b wb=%0b exp 0/0/0",
                    resp_valid, resp_fault, resp_writeback));
    rst_n = 1'b1;
    @(negedge clk);
    check(!resp_valid, "R2", $sformatf("idle resp_valid=%0b exp 0", resp_valid));

    for (int a = 0; a < 4; a++)
      for (int pr = 0; pr < 2; pr++)
        for (int pt = 0; pt < 2; pt++)
          for (int m = 0; m < 8; m++)
            for (int au = 0; au < 16; au++)
              for (int at = 0; at < 4; at++)
                for (int rc = 0; rc < 4; rc++) begin
                  logic [63:0] p;
                  p = 64'h5A3C_96E1_0F00_0000 ^ (64'(au * 37 + m) << 24);
                  p[8] = rc[1]; p[7] = rc[0]; p[5:4] = at[1:0]; p[3:0] = au[3:0];
                  req_pte = p; req_access = a[1:0]; req_problem = pr[0];
                  req_partition = pt[0]; req_amr_rights = m[2:0];
                  req_valid = 1'b1;
                  model(p, a[1:0], pr[0], pt[0], m[2:0]);
                  @(negedge clk);
                  check(resp_valid && resp_fault == e_fault && resp_cause == e_cause &&
                        resp_rights == e_rights && resp_pte == e_pte, e_tag,
                        $sformatf("acc=%0d pte=%h f=%0b c=%h r=%b p=%h exp f=%0b c=%h r=%b p=%h",
                                  a, p, resp_fault, resp_cause, resp_rights, resp_pte,
                                  e_fault, e_cause, e_rights, e_pte));
                  check(resp_writeback == e_wb, "R10",
                        $sformatf("acc=%0d pte=%h wb=%0b exp %0b", a, p, resp_writeback, e_wb));
                end

    req_valid = 1'b0;
    @(negedge clk);
    check(!resp_valid && !resp_writeback, "R2",
          $sformatf("after stop v=%0b wb=%0b exp 0/0", resp_valid, resp_writeback));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule